// File: doc/BRIEF.md
# Three-Pair PWM Output Polarity Stage

This block sits between a PWM generator and the pads of three half-bridge channel pairs. Each pair has a high-side and a low-side pin. The generator supplies a raw active request for each side. The block turns each request into a pin level and drives a per-pin output-enable for the tri-state pad. Two option bits set the inactive (off) level: one bit covers every high-side pin and the other covers every low-side pin. A pin that is active drives the inverse of its option bit.

A per-pair polarity bit swaps which request drives which pin, so the low side can lead the period instead of the high side. The off levels stay where the option bits put them. A polarity request is held pending and is applied only at a reload strobe. In complementary mode it waits further, for the first deadband-complete strobe after that reload. The pads float while reset is asserted. After reset is released, only pairs whose enable bit is set are driven, so a disabled pair's pins stay free for general-purpose input.

Top module: `pwm_pair_outstage`

## Requirements
- R1: When a side of an enabled pair has no active request, its high-side pin drives `off_hi` and its low-side pin drives `off_lo`.
- R2: An active pin drives the inverse of its side's option bit (`~off_hi` for high-side pins, `~off_lo` for low-side pins).
- R3: With the applied polarity of a pair at 0, `pin_hi` follows `raw_hi` and `pin_lo` follows `raw_lo`, so the high side leads a period.
- R4: With the applied polarity of a pair at 1, `pin_hi` follows `raw_lo` and `pin_lo` follows `raw_hi`, so the low side leads a period. The off levels are unchanged.
- R5: A change on `pol_pend` without a qualifying strobe has no effect on the pins.
- R6: With `comp_mode` at 0, `pol_pend` is taken into the applied polarity on the edge where `reload_stb` is 1. Pins registered on the following edge use the new polarity.
- R7: With `comp_mode` at 1, `reload_stb` captures `pol_pend` but does not apply it. The captured value, not any later `pol_pend`, is applied at the first later edge with `deadband_done` at 1. A `deadband_done` with no pending capture has no effect.
- R8: While `rst_n` is 0, every output-enable is 0 (the pads float).
- R9: On each edge after reset is released, a pair's two output-enables take the value of its `pair_en` bit. An enabled pair with no requests then drives its off levels.
- R10: A pair whose `pair_en` bit is 0 keeps both output-enables at 0, independently of the other pairs.
- R11: Pin levels and output-enables are registered: each reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_en | input | N_PAIRS | Per-pair drive enable |
| off_hi | input | 1 | Off level of all high-side pins |
| off_lo | input | 1 | Off level of all low-side pins |
| comp_mode | input | 1 | 1: polarity change also waits for deadband end |
| pol_pend | input | N_PAIRS | Requested relative polarity per pair |
| reload_stb | input | 1 | PWM reload event strobe |
| deadband_done | input | 1 | Deadband-complete strobe |
| raw_hi | input | N_PAIRS | High-side active request from the generator |
| raw_lo | input | N_PAIRS | Low-side active request from the generator |
| pin_hi | output | N_PAIRS | High-side pin level |
| pin_lo | output | N_PAIRS | Low-side pin level |
| pin_oe_hi | output | N_PAIRS | High-side pad output-enable |
| pin_oe_lo | output | N_PAIRS | Low-side pad output-enable |

## Verification
The assertions check the following on every cycle. A disabled pair never drives and an enabled pair always drives. Both pins of a pair share one enable. A cycle with no request yields the off levels. The applied polarity moves only on the strobe that qualifies it for the current mode. The bench covers what needs a reference model: the full level mapping, swept over every off-bit combination, both polarities and all request patterns. It also covers the exact edge on which a new polarity reaches the pins, the capture-then-apply sequence in complementary mode, and the float-then-drive behaviour around reset.

// File: rtl/pwm_os_pkg.sv
package pwm_os_pkg;

    // Polarity tracking for one channel pair
    typedef struct packed {
        logic pol;    // polarity in use
        logic armed;  // a captured value waits for deadband end
        logic hold;   // value captured at reload
    } pol_state_t;

    // Registered pad state for one channel pair
    typedef struct packed {
        logic hi;
        logic lo;
        logic oe;
    } pair_pad_t;

endpackage

// File: rtl/pwm_os_polsel.sv
module pwm_os_polsel
    import pwm_os_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic comp_mode,
    input  logic reload_stb,
    input  logic deadband_done,
    input  logic pol_new,
    output logic pol_o
);

    pol_state_t st_d;
    pol_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!comp_mode) begin
            st_d.armed = 1'b0;
            if (reload_stb) begin
                st_d.pol = pol_new;
            end
        end else begin
            if (deadband_done && st_q.armed) begin
                st_d.pol   = st_q.hold;
                st_d.armed = 1'b0;
            end
            if (reload_stb) begin
                st_d.hold  = pol_new;
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_o = st_q.pol;

endmodule

// File: rtl/pwm_os_levmap.sv
module pwm_os_levmap (
    input  logic pol,
    input  logic req_hi,
    input  logic req_lo,
    input  logic off_hi,
    input  logic off_lo,
    output logic lvl_hi,
    output logic lvl_lo
);

    logic act_hi;
    logic act_lo;

    always_comb begin
        act_hi = pol ? req_lo : req_hi;
        act_lo = pol ? req_hi : req_lo;
        // active drives the inverse of the off level
        lvl_hi = off_hi ^ act_hi;
        lvl_lo = off_lo ^ act_lo;
    end

endmodule

// File: rtl/pwm_pair_outstage.sv
module pwm_pair_outstage
    import pwm_os_pkg::*;
#(
    parameter int N_PAIRS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PAIRS-1:0] pair_en,
    input  logic               off_hi,
    input  logic               off_lo,
    input  logic               comp_mode,
    input  logic [N_PAIRS-1:0] pol_pend,
    input  logic               reload_stb,
    input  logic               deadband_done,
    input  logic [N_PAIRS-1:0] raw_hi,
    input  logic [N_PAIRS-1:0] raw_lo,
    output logic [N_PAIRS-1:0] pin_hi,
    output logic [N_PAIRS-1:0] pin_lo,
    output logic [N_PAIRS-1:0] pin_oe_hi,
    output logic [N_PAIRS-1:0] pin_oe_lo
);

    localparam int LAST = N_PAIRS - 1;

    logic [LAST:0] pol_cur;
    logic [LAST:0] lvl_hi;
    logic [LAST:0] lvl_lo;

    pair_pad_t [LAST:0] pad_d;
    pair_pad_t [LAST:0] pad_q;

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        pwm_os_polsel i_polsel (
            .clk           (clk),
            .rst_n         (rst_n),
            .comp_mode     (comp_mode),
            .reload_stb    (reload_stb),
            .deadband_done (deadband_done),
            .pol_new       (pol_pend[g]),
            .pol_o         (pol_cur[g])
        );

        pwm_os_levmap i_levmap (
            .pol    (pol_cur[g]),
            .req_hi (raw_hi[g]),
            .req_lo (raw_lo[g]),
            .off_hi (off_hi),
            .off_lo (off_lo),
            .lvl_hi (lvl_hi[g]),
            .lvl_lo (lvl_lo[g])
        );
    end

    always_comb begin
        pad_d = pad_q;
        for (int i = 0; i < N_PAIRS; i++) begin
            pad_d[i].hi = lvl_hi[i];
            pad_d[i].lo = lvl_lo[i];
            pad_d[i].oe = pair_en[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_q <= '0;
        end else begin
            pad_q <= pad_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N_PAIRS; i++) begin
            pin_hi[i]    = pad_q[i].hi;
            pin_lo[i]    = pad_q[i].lo;
            pin_oe_hi[i] = pad_q[i].oe;
            pin_oe_lo[i] = pad_q[i].oe;
        end
    end

endmodule

// File: rtl/pwm_os_chk.sv
module pwm_os_chk #(
    parameter int N_PAIRS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PAIRS-1:0] pair_en,
    input logic               off_hi,
    input logic               off_lo,
    input logic               comp_mode,
    input logic [N_PAIRS-1:0] pol_pend,
    input logic               reload_stb,
    input logic               deadband_done,
    input logic [N_PAIRS-1:0] raw_hi,
    input logic [N_PAIRS-1:0] raw_lo,
    input logic [N_PAIRS-1:0] pin_hi,
    input logic [N_PAIRS-1:0] pin_lo,
    input logic [N_PAIRS-1:0] pin_oe_hi,
    input logic [N_PAIRS-1:0] pin_oe_lo,
    input logic [N_PAIRS-1:0] pol_cur
);

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_chk
        // R10: a disabled pair floats on the next edge
        a_r10_disabled_floats: assert property (@(posedge clk) disable iff (!rst_n)
            !pair_en[g] |=> (!pin_oe_hi[g] && !pin_oe_lo[g]));

        // R9: an enabled pair drives on the next edge
        a_r9_enabled_drives: assert property (@(posedge clk) disable iff (!rst_n)
            pair_en[g] |=> (pin_oe_hi[g] && pin_oe_lo[g]));

        // R1: no request gives the off levels on the next edge
        a_r1_idle_off_level: assert property (@(posedge clk) disable iff (!rst_n)
            (!raw_hi[g] && !raw_lo[g]) |=>
            (pin_hi[g] == $past(off_hi) && pin_lo[g] == $past(off_lo)));

        // R5: no qualifying strobe leaves the polarity alone
        a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            (!reload_stb && !deadband_done) |=> $stable(pol_cur[g]));

        // R6: plain mode applies the pending polarity at reload
        a_r6_plain_reload_applies: assert property (@(posedge clk) disable iff (!rst_n)
            (!comp_mode && reload_stb) |=> (pol_cur[g] == $past(pol_pend[g])));

        // R6: plain mode ignores the deadband strobe
        a_r6_plain_ignores_deadband: assert property (@(posedge clk) disable iff (!rst_n)
            (!comp_mode && !reload_stb) |=> $stable(pol_cur[g]));

        // R7: complementary mode does not apply at reload alone
        a_r7_comp_reload_waits: assert property (@(posedge clk) disable iff (!rst_n)
            (comp_mode && reload_stb && !deadband_done) |=> $stable(pol_cur[g]));
    end

endmodule

bind pwm_pair_outstage pwm_os_chk #(.N_PAIRS(N_PAIRS)) i_pwm_os_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pair_en       (pair_en),
    .off_hi        (off_hi),
    .off_lo        (off_lo),
    .comp_mode     (comp_mode),
    .pol_pend      (pol_pend),
    .reload_stb    (reload_stb),
    .deadband_done (deadband_done),
    .raw_hi        (raw_hi),
    .raw_lo        (raw_lo),
    .pin_hi        (pin_hi),
    .pin_lo        (pin_lo),
    .pin_oe_hi     (pin_oe_hi),
    .pin_oe_lo     (pin_oe_lo),
    .pol_cur       (pol_cur)
);

// File: tb/test_pwm_pair_outstage.sv
`timescale 1ns/1ps
module test_pwm_pair_outstage;

    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pair_en = '0;
    logic          off_hi = 1'b0;
    logic          off_lo = 1'b0;
    logic          comp_mode = 1'b0;
    logic [NP-1:0] pol_pend = '0;
    logic          reload_stb = 1'b0;
    logic          deadband_done = 1'b0;
    logic [NP-1:0] raw_hi = '0;
    logic [NP-1:0] raw_lo = '0;
    logic [NP-1:0] pin_hi;
    logic [NP-1:0] pin_lo;
    logic [NP-1:0] pin_oe_hi;
    logic [NP-1:0] pin_oe_lo;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [NP-1:0] ref_pol = '0;

    always #2 clk = ~clk;

    pwm_pair_outstage #(.N_PAIRS(NP)) i_pwm_pair_outstage (
        .clk           (clk),
        .rst_n         (rst_n),
        .pair_en       (pair_en),
        .off_hi        (off_hi),
        .off_lo        (off_lo),
        .comp_mode     (comp_mode),
        .pol_pend      (pol_pend),
        .reload_stb    (reload_stb),
        .deadband_done (deadband_done),
        .raw_hi        (raw_hi),
        .raw_lo        (raw_lo),
        .pin_hi        (pin_hi),
        .pin_lo        (pin_lo),
        .pin_oe_hi     (pin_oe_hi),
        .pin_oe_lo     (pin_oe_lo)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected pin levels from the inputs held over the last edge and ref_pol
    task automatic chk_pins(input string req);
        for (int i = 0; i < NP; i++) begin
            logic ah;
            logic al;
            ah = ref_pol[i] ? raw_lo[i] : raw_hi[i];
            al = ref_pol[i] ? raw_hi[i] : raw_lo[i];
            chk(req, {7'd0, pin_hi[i]}, {7'd0, off_hi ^ ah});
            chk(req, {7'd0, pin_lo[i]}, {7'd0, off_lo ^ al});
        end
    endtask

    task automatic set_pol_plain(input logic [NP-1:0] v);
        comp_mode  = 1'b0;
        pol_pend   = v;
        reload_stb = 1'b1;
        step();
        reload_stb = 1'b0;
        ref_pol    = v;
        step();
    endtask

    initial begin
        // R8: reset holds every pad floating
        pair_en = 3'b101;
        off_hi  = 1'b1;
        off_lo  = 1'b0;
        step();
        step();
        chk("R8 oe_hi in reset", {5'd0, pin_oe_hi}, 8'h00);
        chk("R8 oe_lo in reset", {5'd0, pin_oe_lo}, 8'h00);

        // R9/R10: release, enabled pairs drive off levels
        rst_n = 1'b1;
        step();
        chk("R9 oe_hi after release", {5'd0, pin_oe_hi}, 8'h05);
        chk("R10 oe_lo after release", {5'd0, pin_oe_lo}, 8'h05);
        chk("R9 hi off level", {5'd0, pin_hi}, 8'h07);
        chk("R9 lo off level", {5'd0, pin_lo}, 8'h00);

        // R10: disabling one pair leaves the others driving
        pair_en = 3'b110;
        step();
        chk("R10 oe_hi per pair", {5'd0, pin_oe_hi}, 8'h06);
        chk("R10 oe_lo per pair", {5'd0, pin_oe_lo}, 8'h06);
        pair_en = 3'b111;

        // R1-R4, R11: sweep off bits, polarity and every request pattern
        for (int offs = 0; offs < 4; offs++) begin
            for (int pv = 0; pv < 4; pv++) begin
                logic [NP-1:0] pset;
                pset = (pv == 0) ? 3'b000 : (pv == 1) ? 3'b111 :
                       (pv == 2) ? 3'b101 : 3'b010;
                off_hi = offs[1];
                off_lo = offs[0];
                set_pol_plain(pset);
                for (int r = 0; r < 64; r++) begin
                    raw_hi = r[2:0];
                    raw_lo = r[5:3];
                    step();
                    chk_pins("R1 R2 R3 R4 R11 level map");
                end
            end
        end

        // R5: pending change without a strobe is ignored
        off_hi = 1'b0;
        off_lo = 1'b1;
        set_pol_plain(3'b000);
        raw_hi   = 3'b111;
        raw_lo   = 3'b000;
        pol_pend = 3'b111;
        step();
        step();
        chk("R5 hi stays with raw_hi", {5'd0, pin_hi}, 8'h07);
        chk("R5 lo stays idle", {5'd0, pin_lo}, 8'h07);

        // R6: plain mode, new polarity reaches pins one edge after the reload edge
        reload_stb = 1'b1;
        step();
        reload_stb = 1'b0;
        chk("R6 reload edge still old", {5'd0, pin_hi}, 8'h07);
        step();
        ref_pol = 3'b111;
        chk("R6 hi after reload", {5'd0, pin_hi}, 8'h00);
        chk("R6 lo after reload", {5'd0, pin_lo}, 8'h00);
        chk_pins("R6 swapped map");

        // R7: complementary mode, capture at reload, apply at deadband end
        comp_mode  = 1'b1;
        pol_pend   = 3'b000;
        reload_stb = 1'b1;
        step();
        reload_stb = 1'b0;
        pol_pend   = 3'b111;
        step();
        step();
        chk("R7 reload alone waits", {5'd0, pin_hi}, 8'h00);
        deadband_done = 1'b1;
        step();
        deadband_done = 1'b0;
        step();
        ref_pol = 3'b000;
        chk("R7 applied captured value hi", {5'd0, pin_hi}, 8'h07);
        chk("R7 applied captured value lo", {5'd0, pin_lo}, 8'h07);
        deadband_done = 1'b1;
        step();
        deadband_done = 1'b0;
        step();
        chk("R7 deadband without capture ignored", {5'd0, pin_hi}, 8'h07);
        chk_pins("R7 map unchanged");

        // R8: reset asserted mid-run floats the pads at once
        rst_n = 1'b0;
        #1;
        chk("R8 oe_hi mid-run reset", {5'd0, pin_oe_hi}, 8'h00);
        chk("R8 oe_lo mid-run reset", {5'd0, pin_oe_lo}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule